// File: doc/BRIEF.md
# Cascadable Four-Bit ALU with Magnitude Compare

This block is a purely combinational arithmetic/logic unit. It is built from four-bit slices chained into a word of `SLICES` slices. Each slice takes two operand nibbles, a four-bit select code and a mode bit. It returns a result nibble, an active-low carry, active-low group generate and propagate flags, and an all-ones flag.

With `mode_logic` high, no carry enters the result. The select code then picks one of sixteen bitwise functions of the two operands. With `mode_logic` low, the slice adds two select-dependent addends plus the incoming carry. Carries pass from slice to slice by direct ripple.

Comparison uses the subtract code. The all-ones flags of all slices are ANDed into a word-level equality signal. The final carry, read together with the carry-in level, yields a magnitude flag. The parameter `DATA_ACTIVE_LOW` states whether the operands are stored inverted, and the flag's meaning is flipped to match.

Top module: `alu_ripple`

## Requirements
- R1: With `mode_logic`=1, `f_out` per select code `sel` (binary, bit 3 first) is: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 zero, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `mode_logic`=0, `f_out` is (X + Y + c) modulo 2^W. Here c=1 when `carry_in_n`=0 and c=0 otherwise. The pair (X, Y) per code is: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (ones,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,ones), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A&B,ones), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (ones,A).
- R3: Code 1001 with `mode_logic`=0 gives A plus B plus c, with the carry out of the word on `carry_out_n`.
- R4: Code 0110 with `mode_logic`=0 gives A minus B minus 1 when `carry_in_n`=1, and A minus B when `carry_in_n`=0.
- R5: `carry_out_n` is 0 exactly when X + Y + c of R2 reaches 2^W, in either mode.
- R6: For slice k (bits 4k+3..4k), `grp_gen_n[k]` is 0 exactly when X+Y over that nibble exceeds 15. `grp_prop_n[k]` is 0 exactly when every bit of that nibble of X|Y is 1. Both hold in either mode.
- R7: `all_ones` is 1 exactly when every bit of `f_out` is 1. With code 0110, `mode_logic`=0 and `carry_in_n`=1, it is therefore 1 exactly when A equals B.
- R8: With `DATA_ACTIVE_LOW`=0, code 0110, `mode_logic`=0: `a_wins` is 1 exactly when A>B if `carry_in_n`=1, and when A>=B if `carry_in_n`=0.
- R9: With `DATA_ACTIVE_LOW`=1 and the same code, the true operands are ~A and ~B. `a_wins` is 1 exactly when ~A>=~B if `carry_in_n`=1, and when ~A>~B if `carry_in_n`=0.
- R10: The carry of each slice enters the next slice, so a carry out of bit 3 reaches bit 4.
- R11: With `mode_logic`=1, `f_out` is the same for both levels of `carry_in_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| sel | input | 4 | Function select code |
| mode_logic | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in_n | input | 1 | Active-low carry into slice 0 |
| f_out | output | W | Result |
| carry_out_n | output | 1 | Active-low carry out of the last slice |
| grp_gen_n | output | SLICES | Active-low group generate, one per slice |
| grp_prop_n | output | SLICES | Active-low group propagate, one per slice |
| all_ones | output | 1 | AND of all slice all-ones flags |
| a_wins | output | 1 | Magnitude flag, valid in subtract mode |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle its stimulus is applied, with no register in between. The bench applies a new vector just after each rising edge. It compares all outputs half a period later, at the falling edge, against a model built from the function tables. It sweeps every nibble pair through each slice for all select, mode and carry-in combinations, then adds random full-width vectors and directed ripple cases. A second instance with inverted-data decoding shares the same inputs so that its magnitude flag is checked on every subtract vector.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned SLICE_W = 4;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_ADD = 4'b1001;
endpackage

// File: rtl/alu_addend_gen.sv
// Per-bit addend terms chosen by the select code.
// or_term is the wide addend, and_term the narrow one (and_term implies or_term).
module alu_addend_gen #(
  parameter int unsigned W = alu_pkg::SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  output logic [W-1:0] or_term,
  output logic [W-1:0] and_term
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign or_term[i]  = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
    assign and_term[i] = (a[i] & b[i] & sel[3]) | (a[i] & ~b[i] & sel[2]);
  end
endmodule

// File: rtl/alu_carry_chain.sv
// Carry chain over one slice, with group generate/propagate (active high).
module alu_carry_chain #(
  parameter int unsigned W = alu_pkg::SLICE_W
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         cin,
  output logic [W:0]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  assign carry[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_c
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end

  always_comb begin
    grp_gen  = 1'b0;
    grp_prop = 1'b1;
    for (int i = 0; i < W; i++) begin
      grp_gen  = gen[i] | (prop[i] & grp_gen);
      grp_prop = grp_prop & prop[i];
    end
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int unsigned W = alu_pkg::SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  input  logic         mode_logic,
  input  logic         cin_n,
  output logic [W-1:0] f,
  output logic         cout_n,
  output logic         gen_n,
  output logic         prop_n,
  output logic         eq
);
  logic [W-1:0] or_t, and_t, gen, prop;
  logic [W:0]   carry;
  logic         gg, gp;

  alu_addend_gen #(.W(W)) u_terms (
    .a(a), .b(b), .sel(sel), .or_term(or_t), .and_term(and_t)
  );

  assign gen  = or_t & and_t;
  assign prop = or_t | and_t;

  alu_carry_chain #(.W(W)) u_chain (
    .gen(gen), .prop(prop), .cin(~cin_n),
    .carry(carry), .grp_gen(gg), .grp_prop(gp)
  );

  for (genvar i = 0; i < W; i++) begin : g_f
    assign f[i] = mode_logic ? ~(or_t[i] ^ and_t[i])
                             : (or_t[i] ^ and_t[i] ^ carry[i]);
  end

  assign cout_n = ~carry[W];
  assign gen_n  = ~gg;
  assign prop_n = ~gp;
  assign eq     = &f;
endmodule

// File: rtl/alu_mag_decode.sv
// Reads the final active-low carry as "A is the larger side".
module alu_mag_decode #(
  parameter bit ACT_LOW = 1'b0
) (
  input  logic cout_n,
  output logic a_wins
);
  if (ACT_LOW) begin : g_low
    assign a_wins = cout_n;
  end else begin : g_high
    assign a_wins = ~cout_n;
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int unsigned SLICES          = 2,
  parameter bit          DATA_ACTIVE_LOW = 1'b0
) (
  input  logic [SLICES*alu_pkg::SLICE_W-1:0] a_in,
  input  logic [SLICES*alu_pkg::SLICE_W-1:0] b_in,
  input  logic [3:0]                         sel,
  input  logic                               mode_logic,
  input  logic                               carry_in_n,
  output logic [SLICES*alu_pkg::SLICE_W-1:0] f_out,
  output logic                               carry_out_n,
  output logic [SLICES-1:0]                  grp_gen_n,
  output logic [SLICES-1:0]                  grp_prop_n,
  output logic                               all_ones,
  output logic                               a_wins
);
  localparam int unsigned SW = alu_pkg::SLICE_W;
  localparam int unsigned W  = SLICES * SW;

  logic [SLICES:0]   chain_n;
  logic [SLICES-1:0] eq_vec;

  assign chain_n[0] = carry_in_n;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    alu_slice #(.W(SW)) u_slice (
      .a          (a_in[k*SW +: SW]),
      .b          (b_in[k*SW +: SW]),
      .sel        (sel),
      .mode_logic (mode_logic),
      .cin_n      (chain_n[k]),
      .f          (f_out[k*SW +: SW]),
      .cout_n     (chain_n[k+1]),
      .gen_n      (grp_gen_n[k]),
      .prop_n     (grp_prop_n[k]),
      .eq         (eq_vec[k])
    );
  end

  assign carry_out_n = chain_n[SLICES];
  assign all_ones    = &eq_vec;

  alu_mag_decode #(.ACT_LOW(DATA_ACTIVE_LOW)) u_mag (
    .cout_n (chain_n[SLICES]),
    .a_wins (a_wins)
  );
endmodule

// File: rtl/alu_ripple_chk.sv
module alu_ripple_chk #(
  parameter int unsigned W       = 8,
  parameter bit          ACT_LOW = 1'b0
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [3:0]   sel,
  input logic         mode_logic,
  input logic         carry_in_n,
  input logic [W-1:0] f_out,
  input logic         carry_out_n,
  input logic         all_ones,
  input logic         a_wins
);
  logic         is_sub, is_add;
  logic [W:0]   add_exp;
  logic [W-1:0] sub_exp;

  assign is_sub  = !mode_logic && (sel == alu_pkg::SEL_SUB);
  assign is_add  = !mode_logic && (sel == alu_pkg::SEL_ADD);
  assign add_exp = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, ~carry_in_n};
  assign sub_exp = a_in - b_in - {{(W-1){1'b0}}, carry_in_n};

  always_comb begin
    if (is_add) begin
      // R3
      add_sum_chk: assert ({~carry_out_n, f_out} == add_exp);
    end
    if (is_sub) begin
      // R4
      sub_diff_chk: assert (f_out == sub_exp);
    end
    if (is_sub && carry_in_n) begin
      // R7
      sub_equal_chk: assert (all_ones == (a_in == b_in));
    end
    if (is_sub) begin
      // R8
      mag_flag_chk: assert (ACT_LOW ||
        (a_wins == (carry_in_n ? (a_in > b_in) : (a_in >= b_in))));
      // R9
      mag_inv_chk: assert (!ACT_LOW ||
        (a_wins == (carry_in_n ? (~a_in >= ~b_in) : (~a_in > ~b_in))));
    end
    if (mode_logic && sel == alu_pkg::SEL_SUB) begin
      // R1
      logic_xor_chk: assert (f_out == (a_in ^ b_in));
    end
  end
endmodule

bind alu_ripple alu_ripple_chk #(.W(W), .ACT_LOW(DATA_ACTIVE_LOW)) u_chk (
  .a_in        (a_in),
  .b_in        (b_in),
  .sel         (sel),
  .mode_logic  (mode_logic),
  .carry_in_n  (carry_in_n),
  .f_out       (f_out),
  .carry_out_n (carry_out_n),
  .all_ones    (all_ones),
  .a_wins      (a_wins)
);

// File: tb/tb_alu_ripple.sv
`timescale 1ns/1ps
module tb_alu_ripple;
  localparam int SL = 2;
  localparam int W  = 8;
  localparam int MASK = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  a_in, b_in, f_out, f_inv;
  logic [3:0]    sel;
  logic          mode_logic, carry_in_n;
  logic          carry_out_n, all_ones, a_wins;
  logic [SL-1:0] grp_gen_n, grp_prop_n, gg_inv, gp_inv;
  logic          co_inv, eq_inv, wins_inv;

  alu_ripple #(.SLICES(SL), .DATA_ACTIVE_LOW(1'b0)) dut (
    .a_in(a_in), .b_in(b_in), .sel(sel), .mode_logic(mode_logic),
    .carry_in_n(carry_in_n), .f_out(f_out), .carry_out_n(carry_out_n),
    .grp_gen_n(grp_gen_n), .grp_prop_n(grp_prop_n),
    .all_ones(all_ones), .a_wins(a_wins)
  );

  alu_ripple #(.SLICES(SL), .DATA_ACTIVE_LOW(1'b1)) dut_inv (
    .a_in(a_in), .b_in(b_in), .sel(sel), .mode_logic(mode_logic),
    .carry_in_n(carry_in_n), .f_out(f_inv), .carry_out_n(co_inv),
    .grp_gen_n(gg_inv), .grp_prop_n(gp_inv),
    .all_ones(eq_inv), .a_wins(wins_inv)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Addend pair per select code, from the R2 table.
  task automatic addends(input int a, input int b, input int s, output int x, output int y);
    int nb;
    nb = ~b & MASK;
    case (s)
      0:  begin x = a;      y = 0;      end
      1:  begin x = a | b;  y = 0;      end
      2:  begin x = a | nb; y = 0;      end
      3:  begin x = MASK;   y = 0;      end
      4:  begin x = a;      y = a & nb; end
      5:  begin x = a | b;  y = a & nb; end
      6:  begin x = a;      y = nb;     end
      7:  begin x = a & nb; y = MASK;   end
      8:  begin x = a;      y = a & b;  end
      9:  begin x = a;      y = b;      end
      10: begin x = a | nb; y = a & b;  end
      11: begin x = a & b;  y = MASK;   end
      12: begin x = a;      y = a;      end
      13: begin x = a | b;  y = a;      end
      14: begin x = a | nb; y = a;      end
      default: begin x = MASK; y = a;   end
    endcase
  endtask

  function automatic int logic_ref(input int a, input int b, input int s);
    int r;
    case (s)
      0:  r = ~a;
      1:  r = ~(a | b);
      2:  r = ~a & b;
      3:  r = 0;
      4:  r = ~(a & b);
      5:  r = ~b;
      6:  r = a ^ b;
      7:  r = a & ~b;
      8:  r = ~a | b;
      9:  r = ~(a ^ b);
      10: r = b;
      11: r = a & b;
      12: r = MASK;
      13: r = a | ~b;
      14: r = a | b;
      default: r = a;
    endcase
    return r & MASK;
  endfunction

  task automatic run_vec(input int a, input int b, input int s, input int m, input int cn);
    int x, y, sum, fexp, coexp, at, bt, wexp, winv;
    @(posedge clk);
    a_in = a[W-1:0]; b_in = b[W-1:0]; sel = s[3:0];
    mode_logic = m[0]; carry_in_n = cn[0];
    addends(a, b, s, x, y);
    sum   = x + y + (cn != 0 ? 0 : 1);
    coexp = (sum > MASK) ? 0 : 1;
    fexp  = (m != 0) ? logic_ref(a, b, s) : (sum & MASK);
    @(negedge clk);
    if (m != 0) begin
      if (cn == 0) chk("R11", "f_out logic cin0", int'(f_out), fexp);
      else         chk("R1",  "f_out logic", int'(f_out), fexp);
    end else if (s == 9) chk("R3", "f_out add", int'(f_out), fexp);
    else if (s == 6)     chk("R4", "f_out sub", int'(f_out), fexp);
    else                 chk("R2", "f_out arith", int'(f_out), fexp);
    chk("R5", "carry_out_n", int'(carry_out_n), coexp);
    for (int k = 0; k < SL; k++) begin
      chk("R6", "grp_gen_n", int'(grp_gen_n[k]),
          ((((x >> (4*k)) & 15) + ((y >> (4*k)) & 15)) > 15) ? 0 : 1);
      chk("R6", "grp_prop_n", int'(grp_prop_n[k]),
          ((((x | y) >> (4*k)) & 15) == 15) ? 0 : 1);
    end
    chk("R7", "all_ones", int'(all_ones), (fexp == MASK) ? 1 : 0);
    if (m == 0 && s == 6) begin
      at = ~a & MASK; bt = ~b & MASK;
      wexp = (cn != 0) ? ((a > b) ? 1 : 0) : ((a >= b) ? 1 : 0);
      winv = (cn != 0) ? ((at >= bt) ? 1 : 0) : ((at > bt) ? 1 : 0);
      chk("R8", "a_wins", int'(a_wins), wexp);
      chk("R9", "a_wins inverted", int'(wins_inv), winv);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    a_in = '0; b_in = '0; sel = 4'd0; mode_logic = 1'b0; carry_in_n = 1'b1;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Quiet state: code 0000 arithmetic, no carry: result zero, no carry out.
    chk("R2", "idle f_out", int'(f_out), 0);
    chk("R5", "idle carry_out_n", int'(carry_out_n), 1);
    chk("R7", "idle all_ones", int'(all_ones), 0);

    // Ripple across the slice boundary.
    run_vec(8'h0F, 8'h01, 9, 0, 1);
    chk("R10", "ripple 0F+01", int'(f_out), 8'h10);
    run_vec(8'h0F, 8'h00, 9, 0, 0);
    chk("R10", "ripple 0F+cin", int'(f_out), 8'h10);
    run_vec(8'hFF, 8'h01, 9, 0, 1);
    chk("R10", "wrap carry", int'(carry_out_n), 0);
    // Equality boundaries.
    run_vec(8'h5A, 8'h5A, 6, 0, 1);
    chk("R7", "equal operands", int'(all_ones), 1);
    run_vec(8'h00, 8'hFF, 6, 0, 1);
    run_vec(8'hFF, 8'h00, 6, 0, 0);

    // Every nibble pair through both slices for each code, mode, carry.
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int cn = 0; cn < 2; cn++)
          for (int p = 0; p < 16; p++)
            for (int q = 0; q < 16; q++)
              run_vec((p << 4) | q, (q << 4) | p, s, m, cn);

    // Random full-width vectors.
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int cn = 0; cn < 2; cn++)
          for (int r = 0; r < 150; r++)
            run_vec(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), s, m, cn);

    finish_run();
  end
endmodule